// File: doc/BRIEF.md
# Sound Register Bank with Master Power Gating

This block is the byte-wide register file that sits between the CPU and the sound core of a handheld console. It occupies the I/O window from low address 0x10 to 0x3F. That window holds the channel control registers at 0x10 to 0x25, a master control and status register at 0x26, and a 16-byte wave-pattern RAM at 0x30 to 0x3F. The CPU writes through an address, a strobe and a data byte, and reads back through a combinational data port. Bits that cannot be read come back as ones.

The master enable is bit 7 of 0x26. While it is clear, the control registers refuse new contents, except for a few exceptions that depend on the model. Clearing the master enable wipes every control register at once.

The sound core supplies three things: a channel-3 playing flag, a wave-readable flag, and the current wave window position. While the wave channel runs, the block uses these to steer wave RAM accesses to the byte in use. The core also supplies four channel-active bits, which appear in the status register. A model input selects between the original handheld behaviour (model low) and the colour model behaviour (model high). For each accepted write, the core receives a one-cycle strobe for the register written and the value to apply. The core uses these strobes to detect trigger writes.

Top module: `snd_reg_bank`

## Requirements
- R1: After reset, each control register holds the following value. Address 0x26 stores master enable = 1.

  | Address | Value | Address | Value | Address | Value | Address | Value |
  |---|---|---|---|---|---|---|---|
  | 0x10 | 0x80 | 0x16 | 0x3F | 0x1A | 0x7F | 0x20 | 0xFF |
  | 0x11 | 0xBF | 0x17 | 0x00 | 0x1B | 0xFF | 0x21 | 0x00 |
  | 0x12 | 0xF3 | 0x18 | 0x00 | 0x1C | 0x9F | 0x22 | 0x00 |
  | 0x13 | 0xF3 | 0x19 | 0xBF | 0x1D | 0x00 | 0x23 | 0xBF |
  | 0x14 | 0xBF | | | 0x1E | 0xBF | 0x24 | 0x77 |
  | | | | | | | 0x25 | 0xF3 |

  Wave RAM and the core strobes are zero after reset.
- R2: A read of a control register returns the stored byte ORed with a fixed mask for that register:

  | Mask | Registers |
  |---|---|
  | 0xFF | 0x13, 0x18, 0x1B, 0x1D, 0x20 |
  | 0xBF | 0x14, 0x19, 0x1E, 0x23 |
  | 0x9F | 0x1C |
  | 0x80 | 0x10 |
  | 0x7F | 0x1A |
  | 0x3F | 0x11, 0x16 |
  | 0x00 | 0x12, 0x17, 0x21, 0x22, 0x24, 0x25 |
- R3: While the master enable is clear, a write to any control register from 0x10 to 0x25 stores zero and raises no core strobe, apart from the exceptions in R4.
- R4: The model input selects the exceptions that apply while sound is off.
  - Original model: writes to 0x1B and 0x20 are accepted normally, with stored value and strobe.
  - Original model: writes to 0x11 and 0x16 store zero, but they raise the strobe and forward the written value ANDed with 0x3F.
  - Colour model: none of these exceptions apply.
- R5: A write to 0x26 stores only bit 7 of the data. It strobes with the data ANDed with 0x80. A read of 0x26 returns {master enable, 3'b111, channel_active[3:0]}.
- R6: A write that clears the master enable sets all control registers 0x10 to 0x25 to zero on the same clock edge. Wave RAM is unchanged.
- R7: A wave RAM write goes to byte addr[3:0] if channel 3 is not playing, or if the colour model is selected. On the original model while channel 3 plays, the write goes to byte wave_window[4:1] when the readable flag is set, and is dropped when it is clear.
- R8: A wave RAM read returns byte addr[3:0] while channel 3 is idle. While it plays, the read returns byte wave_window[4:1] if the readable flag is set or the colour model is selected, and 0xFF otherwise.
- R9: Addresses 0x15, 0x1F, 0x27 to 0x2F, and any address outside 0x10 to 0x3F read 0xFF. Writes to them change nothing and raise no strobe.
- R10: An accepted write to address A from 0x10 to 0x26 sets bit A−0x10 of the 23-bit core strobe for exactly the following cycle, with the forwarded byte on the core data port. At most one strobe bit is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Low byte of the I/O address |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |
| cgb_mode | input | 1 | 1 selects colour-model behaviour |
| ch3_playing | input | 1 | Wave channel is running |
| wave_readable | input | 1 | Wave RAM may be accessed while playing |
| wave_window | input | 5 | Current wave sample position |
| ch_active | input | 4 | Channel-active status bits |
| core_wr_strobe | output | 23 | One-cycle write pulse, bit per register 0x10 to 0x26 |
| core_wr_data | output | 8 | Value forwarded with the strobe |

## Verification
The assertions assume that a write and a change in the master enable happen on the same clock edge. They also assume that the sound-core flags, the model input and the wave position stay steady across each write. The bench changes those inputs only between transactions, while wr_en is low. It issues every write as a single-cycle pulse and separates consecutive writes by at least one idle cycle.

// File: rtl/snd_reg_bank.sv
module snd_reg_bank #(
  parameter int NREG      = 23,
  parameter int WAVE_SIZE = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      addr,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  output logic [7:0]      rd_data,
  input  logic            cgb_mode,
  input  logic            ch3_playing,
  input  logic            wave_readable,
  input  logic [4:0]      wave_window,
  input  logic [3:0]      ch_active,
  output logic [NREG-1:0] core_wr_strobe,
  output logic [7:0]      core_wr_data
);
  localparam int WBITS = $clog2(WAVE_SIZE);
  localparam int CTRL  = NREG - 1;

  logic [7:0] regs [NREG];
  logic [7:0] wave [WAVE_SIZE];

  function automatic logic [7:0] rst_val(input logic [4:0] i);
    case (i)
      5'd0:  rst_val = 8'h80;
      5'd1:  rst_val = 8'hBF;
      5'd2:  rst_val = 8'hF3;
      5'd3:  rst_val = 8'hF3;
      5'd4:  rst_val = 8'hBF;
      5'd6:  rst_val = 8'h3F;
      5'd9:  rst_val = 8'hBF;
      5'd10: rst_val = 8'h7F;
      5'd11: rst_val = 8'hFF;
      5'd12: rst_val = 8'h9F;
      5'd14: rst_val = 8'hBF;
      5'd16: rst_val = 8'hFF;
      5'd19: rst_val = 8'hBF;
      5'd20: rst_val = 8'h77;
      5'd21: rst_val = 8'hF3;
      5'd22: rst_val = 8'h80;
      default: rst_val = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rd_mask(input logic [4:0] i);
    case (i)
      5'd0:  rd_mask = 8'h80;
      5'd1, 5'd6: rd_mask = 8'h3F;
      5'd2, 5'd7, 5'd17, 5'd18, 5'd20, 5'd21: rd_mask = 8'h00;
      5'd4, 5'd9, 5'd14, 5'd19: rd_mask = 8'hBF;
      5'd10: rd_mask = 8'h7F;
      5'd12: rd_mask = 8'h9F;
      default: rd_mask = 8'hFF;
    endcase
  endfunction

  logic [7:0] off;
  logic [4:0] ridx;
  logic       snd_on, is_reg, is_ctl, is_stat, is_wave;
  logic [WBITS-1:0] wave_pos, wave_adr;

  assign off      = addr - 8'h10;
  assign ridx     = off[4:0];
  assign snd_on   = regs[CTRL][7];
  assign is_reg   = addr >= 8'h10 && addr <= 8'h26 && addr != 8'h15 && addr != 8'h1F;
  assign is_stat  = addr == 8'h26;
  assign is_ctl   = is_reg && !is_stat;
  assign is_wave  = addr[7:4] == 4'h3;
  assign wave_pos = wave_window[4:1];
  assign wave_adr = addr[WBITS-1:0];

  logic       accept;
  logic [7:0] store_val, fwd_val;

  always_comb begin
    accept    = 1'b0;
    store_val = wr_data;
    fwd_val   = wr_data;
    if (is_stat) begin
      accept    = 1'b1;
      store_val = {wr_data[7], 7'b0};
      fwd_val   = store_val;
    end else if (is_ctl) begin
      if (snd_on) begin
        accept = 1'b1;
      end else if (!cgb_mode && (addr == 8'h1B || addr == 8'h20)) begin
        accept = 1'b1;
      end else begin
        store_val = 8'h00;
        if (!cgb_mode && (addr == 8'h11 || addr == 8'h16)) begin
          accept  = 1'b1;
          fwd_val = wr_data & 8'h3F;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= rst_val(5'(i));
      for (int i = 0; i < WAVE_SIZE; i++) wave[i] <= 8'h00;
      core_wr_strobe <= '0;
      core_wr_data   <= 8'h00;
    end else begin
      core_wr_strobe <= '0;
      if (wr_en && is_reg) begin
        regs[ridx] <= store_val;
        if (accept) begin
          core_wr_strobe[ridx] <= 1'b1;
          core_wr_data         <= fwd_val;
        end
        if (is_stat && !wr_data[7])
          for (int i = 0; i < CTRL; i++) regs[i] <= 8'h00;
      end
      if (wr_en && is_wave) begin
        if (!ch3_playing || cgb_mode) wave[wave_adr] <= wr_data;
        else if (wave_readable)       wave[wave_pos] <= wr_data;
      end
    end
  end

  always_comb begin
    if (is_ctl)       rd_data = regs[ridx] | rd_mask(ridx);
    else if (is_stat) rd_data = {snd_on, 3'b111, ch_active};
    else if (is_wave) begin
      if (!ch3_playing)                   rd_data = wave[wave_adr];
      else if (wave_readable || cgb_mode) rd_data = wave[wave_pos];
      else                                rd_data = 8'hFF;
    end else          rd_data = 8'hFF;
  end

  AST_OFF_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h12 && !snd_on) |=> (regs[2] == 8'h00)); // R3
  AST_OFF_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h24 && !snd_on) |=> (core_wr_strobe == '0)); // R3
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_stat && !wr_data[7]) |=> (!snd_on && regs[0] == 8'h00 && regs[CTRL-1] == 8'h00)); // R6
  AST_WAVE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(snd_on) |-> $stable(wave[0])); // R6
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_wr_strobe)); // R10
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr_strobe != '0) |-> $past(wr_en)); // R10
  AST_HOLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == 8'h15 || addr == 8'h1F)) |=> (core_wr_strobe == '0)); // R9
endmodule

// File: tb/test_snd_reg_bank.sv
`timescale 1ns/1ps
module test_snd_reg_bank;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  addr = 0, wr_data = 0;
  logic        wr_en = 0;
  logic [7:0]  rd_data;
  logic        cgb_mode = 0, ch3_playing = 0, wave_readable = 0;
  logic [4:0]  wave_window = 0;
  logic [3:0]  ch_active = 4'b0101;
  logic [22:0] core_wr_strobe;
  logic [7:0]  core_wr_data;

  int n_chk = 0, n_fail = 0;

  typedef struct {
    int          kind;
    logic [22:0] es;
    logic [7:0]  ed;
    string       req;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  snd_reg_bank i_snd_reg_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cgb_mode(cgb_mode), .ch3_playing(ch3_playing),
    .wave_readable(wave_readable), .wave_window(wave_window), .ch_active(ch_active),
    .core_wr_strobe(core_wr_strobe), .core_wr_data(core_wr_data)
  );

  function automatic logic [22:0] sb(input int idx);
    return 23'(1) << idx;
  endfunction

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string r);
    @(negedge clk);
    addr = a; wr_en = 0;
    q.push_back('{kind: 0, es: '0, ed: e, req: r});
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d,
                    input logic [22:0] es, input logic [7:0] ed, input string r);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1;
    q.push_back('{kind: 1, es: es, ed: ed, req: r});
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    item_t it;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        n_chk++;
        if (it.kind == 0) begin
          if (rd_data !== it.ed) begin
            n_fail++;
            $display("FAIL %s: rd_data actual %h expected %h", it.req, rd_data, it.ed);
          end
        end else begin
          if (core_wr_strobe !== it.es || (it.es != 0 && core_wr_data !== it.ed)) begin
            n_fail++;
            $display("FAIL %s: strobe/data actual %h/%h expected %h/%h",
                     it.req, core_wr_strobe, core_wr_data, it.es, it.ed);
          end
        end
      end
    end
  end

  initial begin
    #(4 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 / R2 reset values through masks
    rd(8'h10, 8'h80, "R1");
    rd(8'h11, 8'hBF, "R1");
    rd(8'h12, 8'hF3, "R1");
    rd(8'h13, 8'hFF, "R2");
    rd(8'h17, 8'h00, "R1");
    rd(8'h24, 8'h77, "R1");
    rd(8'h25, 8'hF3, "R1");
    rd(8'h26, 8'hF5, "R5");
    // R2 / R10 normal writes
    wr(8'h12, 8'h5A, sb(2), 8'h5A, "R10");
    rd(8'h12, 8'h5A, "R2");
    wr(8'h10, 8'h05, sb(0), 8'h05, "R10");
    rd(8'h10, 8'h85, "R2");
    wr(8'h14, 8'h87, sb(4), 8'h87, "R10");
    rd(8'h14, 8'hBF, "R2");
    wr(8'h1C, 8'h20, sb(12), 8'h20, "R10");
    rd(8'h1C, 8'hBF, "R2");
    // R9 unmapped
    wr(8'h15, 8'h33, '0, 8'h00, "R9");
    rd(8'h15, 8'hFF, "R9");
    wr(8'h2A, 8'h33, '0, 8'h00, "R9");
    rd(8'h2A, 8'hFF, "R9");
    rd(8'h05, 8'hFF, "R9");
    // R7 wave direct
    wr(8'h30, 8'h11, '0, 8'h00, "R7");
    wr(8'h3F, 8'hEE, '0, 8'h00, "R7");
    rd(8'h30, 8'h11, "R7");
    rd(8'h3F, 8'hEE, "R7");
    // R5 / R6 master off
    wr(8'h26, 8'h0F, sb(22), 8'h00, "R5");
    rd(8'h26, 8'h75, "R5");
    rd(8'h12, 8'h00, "R6");
    rd(8'h25, 8'h00, "R6");
    rd(8'h10, 8'h80, "R6");
    rd(8'h30, 8'h11, "R6");
    // R3 / R4 sound off
    wr(8'h12, 8'h77, '0, 8'h00, "R3");
    rd(8'h12, 8'h00, "R3");
    wr(8'h24, 8'h66, '0, 8'h00, "R3");
    rd(8'h24, 8'h00, "R3");
    wr(8'h1B, 8'h44, sb(11), 8'h44, "R4");
    wr(8'h20, 8'h21, sb(16), 8'h21, "R4");
    wr(8'h11, 8'hC5, sb(1), 8'h05, "R4");
    rd(8'h11, 8'h3F, "R4");
    wr(8'h16, 8'hFF, sb(6), 8'h3F, "R4");
    rd(8'h16, 8'h3F, "R4");
    cgb_mode = 1;
    wr(8'h1B, 8'h44, '0, 8'h00, "R4");
    wr(8'h11, 8'hC5, '0, 8'h00, "R4");
    cgb_mode = 0;
    // re-enable
    wr(8'h26, 8'hFF, sb(22), 8'h80, "R5");
    rd(8'h26, 8'hF5, "R5");
    wr(8'h24, 8'h12, sb(20), 8'h12, "R10");
    rd(8'h24, 8'h12, "R2");
    // R7 / R8 wave while playing
    ch3_playing = 1; wave_window = 5'd6;
    rd(8'h30, 8'hFF, "R8");
    wr(8'h31, 8'hAB, '0, 8'h00, "R7");
    wave_readable = 1;
    rd(8'h3F, 8'h00, "R8");
    wr(8'h31, 8'hAB, '0, 8'h00, "R7");
    rd(8'h30, 8'hAB, "R8");
    wave_readable = 0; cgb_mode = 1;
    rd(8'h3A, 8'hAB, "R8");
    wr(8'h35, 8'h5C, '0, 8'h00, "R7");
    ch3_playing = 0; cgb_mode = 0;
    rd(8'h35, 8'h5C, "R7");
    rd(8'h31, 8'h00, "R7");
    rd(8'h33, 8'hAB, "R7");
    rd(8'h3F, 8'hEE, "R7");
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule